// File: doc/BRIEF.md
# Partitioned 8x16 SIMD Multiplier

This block multiplies 8-bit pixel components by signed 16-bit scale factors on 64-bit operands, lane by lane. A 3-bit operation code selects how the 8-bit factor and the 16-bit factor of each lane are taken from the two sources. Five operations produce four rounded 16-bit lanes. Two produce two full 32-bit rounded products. The remaining code produces zero.

Every product is formed at 32 bits. A rounding increment of 0x100 is added when the lowest byte of the product is above 0x7F. Narrow operations keep bits 23:8 of that rounded value. Wide operations keep all 32 bits.

The block takes an operation when `in_valid` is high. In the default registered build, the result and `out_valid` appear one clock later and the result register holds between operations. A parameter can select a purely combinational variant.

Top module: `pxmul_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) drives `out_valid` low and `result` to all zeros from the next cycle.
- R2: An operation presented with `in_valid` high at a rising edge appears on `result`, with `out_valid` high, after that edge. A cycle with `in_valid` low drives `out_valid` low after the next edge and leaves `result` unchanged, whatever the other inputs carry.
- R3: With `op` = 0, lane r (r = 0..3) multiplies the unsigned byte `src_a[8r+7:8r]` by the signed factor `src_b[16r+15:16r]`. Its 16-bit result goes to `result[16r+15:16r]`. A zero `src_b` gives a zero result for every defined operation.
- R4: Every lane product is a 32-bit two's-complement value. If its bits 7:0 exceed 0x7F, 0x100 is added modulo 2^32. A narrow lane result is bits 23:8 of the rounded value.
- R5: With `op` = 1, every lane uses `src_b[15:0]` as its signed factor. With `op` = 2, every lane uses `src_b[31:16]`. The pixel byte of lane r is `src_a[8r+7:8r]`, unsigned, as in R3.
- R6: With `op` = 3, the pixel of lane r is the signed byte `src_a[16r+15:16r+8]`, and the factor is `src_b[16r+15:16r]`.
- R7: With `op` = 4, the pixel of lane r is the unsigned byte `src_a[16r+7:16r]`, and the factor is `src_b[16r+15:16r]`.
- R8: With `op` = 5 (signed upper byte, as in R6) or `op` = 6 (unsigned lower byte, as in R7), only lanes 0 and 1 are computed. The full 32-bit rounded product of lane r is placed, unshifted, in `result[32r+31:32r]`.
- R9: With `op` = 7, the result is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 3 | Operation code (0..7) |
| src_a | input | 64 | Pixel source |
| src_b | input | 64 | Scale-factor source |
| out_valid | output | 1 | Result valid |
| result | output | 64 | Packed lane results |

## Verification
The only state is the result register and its valid flag. A fault in either shows on the cycle right after the triggering edge: a lost update, a stale hold or a wrong valid level. Errors in operand selection or rounding are fully combinational and appear in the first result of the affected code. The bench compares each operation against a reference computed from the requirements. It uses hand-picked rounding corners (low byte exactly 0x7F and 0x80, sign of the product) and pseudo-random operands for every code.

// File: rtl/pxmul_pkg.sv
package pxmul_pkg;

   typedef enum logic [2:0] {
      OP_LANE = 3'd0,
      OP_BC0  = 3'd1,
      OP_BC1  = 3'd2,
      OP_HIS  = 3'd3,
      OP_LOU  = 3'd4,
      OP_WHIS = 3'd5,
      OP_WLOU = 3'd6,
      OP_NONE = 3'd7
   } pxmul_op_e;

   typedef enum logic [1:0] {
      PK_NARROW = 2'd0,
      PK_WIDE   = 2'd1,
      PK_ZERO   = 2'd2
   } pxmul_pack_e;

endpackage

// File: rtl/pxmul_opsel.sv
module pxmul_opsel
   import pxmul_pkg::*;
#(
   parameter int PIX_W = 8,
   parameter int FAC_W = 16,
   parameter int NLANE = 4,
   localparam int DATA_W = NLANE * FAC_W
) (
   input  pxmul_op_e                      op,
   input  logic [DATA_W-1:0]              src_a,
   input  logic [DATA_W-1:0]              src_b,
   output logic [NLANE-1:0][PIX_W:0]      pix,
   output logic [NLANE-1:0][FAC_W-1:0]    fac,
   output pxmul_pack_e                    pack
);

   always_comb begin
      unique case (op)
         OP_LANE, OP_BC0, OP_BC1, OP_HIS, OP_LOU: pack = PK_NARROW;
         OP_WHIS, OP_WLOU:                        pack = PK_WIDE;
         default:                                 pack = PK_ZERO;
      endcase
   end

   for (genvar r = 0; r < NLANE; r++) begin : g_lane
      logic [PIX_W-1:0] byte_r;   // byte r of the pixel source
      logic [PIX_W-1:0] hi_r;     // upper byte of factor-width lane r
      logic [PIX_W-1:0] lo_r;     // lower byte of factor-width lane r

      assign byte_r = src_a[PIX_W*r +: PIX_W];
      assign hi_r   = src_a[FAC_W*r + PIX_W +: PIX_W];
      assign lo_r   = src_a[FAC_W*r +: PIX_W];

      always_comb begin
         pix[r] = '0;
         fac[r] = src_b[FAC_W*r +: FAC_W];
         case (op)
            OP_LANE:          pix[r] = {1'b0, byte_r};
            OP_BC0: begin
               pix[r] = {1'b0, byte_r};
               fac[r] = src_b[0 +: FAC_W];
            end
            OP_BC1: begin
               pix[r] = {1'b0, byte_r};
               fac[r] = src_b[FAC_W +: FAC_W];
            end
            OP_HIS, OP_WHIS:  pix[r] = {hi_r[PIX_W-1], hi_r};
            OP_LOU, OP_WLOU:  pix[r] = {1'b0, lo_r};
            default: begin
               pix[r] = '0;
               fac[r] = '0;
            end
         endcase
      end
   end

endmodule

// File: rtl/pxmul_lane.sv
module pxmul_lane #(
   parameter int PIX_W = 8,
   parameter int FAC_W = 16,
   localparam int PROD_W = 2 * FAC_W
) (
   input  logic [PIX_W:0]      pix,   // signed, already extended by one bit
   input  logic [FAC_W-1:0]    fac,   // signed
   output logic [PROD_W-1:0]   rnd
);

   localparam logic [PROD_W-1:0] RND_INC = PROD_W'(1) << PIX_W;

   logic [PROD_W-1:0] pix_x;
   logic [PROD_W-1:0] fac_x;
   logic [PROD_W-1:0] prod;

   // Sign-extend both factors; the low PROD_W bits of the product are
   // then the two's-complement product.
   assign pix_x = {{(PROD_W-PIX_W-1){pix[PIX_W]}}, pix};
   assign fac_x = {{(PROD_W-FAC_W){fac[FAC_W-1]}}, fac};
   assign prod  = pix_x * fac_x;

   // Low byte above half scale is exactly its top bit being set.
   assign rnd = prod[PIX_W-1] ? prod + RND_INC : prod;

endmodule

// File: rtl/pxmul_unit.sv
module pxmul_unit
   import pxmul_pkg::*;
#(
   parameter int PIX_W   = 8,
   parameter int FAC_W   = 16,
   parameter int NLANE   = 4,
   parameter bit REG_OUT = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   in_valid,
   input  logic [2:0]             op,
   input  logic [NLANE*FAC_W-1:0] src_a,
   input  logic [NLANE*FAC_W-1:0] src_b,
   output logic                   out_valid,
   output logic [NLANE*FAC_W-1:0] result
);

   localparam int DATA_W = NLANE * FAC_W;
   localparam int PROD_W = 2 * FAC_W;
   localparam int WIDE_N = NLANE / 2;

   if (FAC_W != 2 * PIX_W) begin : g_bad_width
      $error("pxmul_unit: FAC_W must be twice PIX_W");
   end
   if (NLANE < 2 || (NLANE % 2) != 0) begin : g_bad_lanes
      $error("pxmul_unit: NLANE must be even and at least 2");
   end

   logic [NLANE-1:0][PIX_W:0]     pix;
   logic [NLANE-1:0][FAC_W-1:0]   fac;
   logic [NLANE-1:0][PROD_W-1:0]  rnd;
   pxmul_pack_e                   pack;
   logic [DATA_W-1:0]             comb_res;

   pxmul_opsel #(.PIX_W(PIX_W), .FAC_W(FAC_W), .NLANE(NLANE)) u_sel (
      .op    (pxmul_op_e'(op)),
      .src_a (src_a),
      .src_b (src_b),
      .pix   (pix),
      .fac   (fac),
      .pack  (pack)
   );

   for (genvar r = 0; r < NLANE; r++) begin : g_mul
      pxmul_lane #(.PIX_W(PIX_W), .FAC_W(FAC_W)) u_lane (
         .pix (pix[r]),
         .fac (fac[r]),
         .rnd (rnd[r])
      );
   end

   always_comb begin
      comb_res = '0;
      case (pack)
         PK_NARROW:
            for (int r = 0; r < NLANE; r++)
               comb_res[FAC_W*r +: FAC_W] = rnd[r][PIX_W +: FAC_W];
         PK_WIDE:
            for (int r = 0; r < WIDE_N; r++)
               comb_res[PROD_W*r +: PROD_W] = rnd[r];
         default: comb_res = '0;
      endcase
   end

   if (REG_OUT) begin : g_reg
      logic              valid_q;
      logic [DATA_W-1:0] res_q;

      always_ff @(posedge clk) begin
         if (rst) begin
            valid_q <= 1'b0;
            res_q   <= '0;
         end else begin
            valid_q <= in_valid;
            if (in_valid) res_q <= comb_res;
         end
      end

      assign out_valid = valid_q;
      assign result    = res_q;

      AST_RESET_IDLE: assert property (@(posedge clk)
         rst |=> (!out_valid && result == '0));                                // R1
      AST_VALID_NEXT: assert property (@(posedge clk) disable iff (rst)
         in_valid |=> out_valid);                                              // R2
      AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
         !in_valid |=> (!out_valid && $stable(result)));                       // R2
      AST_ZERO_FACTOR: assert property (@(posedge clk) disable iff (rst)
         (in_valid && src_b == '0) |=> result == '0);                          // R3
      AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
         (in_valid && op == 3'd7) |=> result == '0);                           // R9
   end else begin : g_comb
      assign out_valid = in_valid;
      assign result    = comb_res;
   end

endmodule

// File: tb/sim_pxmul_unit.sv
module sim_pxmul_unit;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [2:0]  op = 3'd0;
   logic [63:0] src_a = '0;
   logic [63:0] src_b = '0;
   logic        out_valid;
   logic [63:0] result;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;
   logic [63:0] seed = 64'h9E37_79B9_7F4A_7C15;

   always #2.5 clk = ~clk;   // 200 MHz

   pxmul_unit u0 (
      .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
      .src_a(src_a), .src_b(src_b), .out_valid(out_valid), .result(result)
   );

   function automatic logic [63:0] next_rand();
      seed = seed ^ (seed << 13);
      seed = seed ^ (seed >> 7);
      seed = seed ^ (seed << 17);
      return seed;
   endfunction

   // Reference built from R3..R9.
   function automatic logic [63:0] ref_mul(input logic [2:0] c,
                                           input logic [63:0] a,
                                           input logic [63:0] b);
      logic [63:0] res = '0;
      for (int r = 0; r < 4; r++) begin
         logic signed [31:0] f, g, p;
         logic [7:0] hb, lb;
         hb = a[16*r+8 +: 8];
         lb = a[16*r +: 8];
         f = $signed({24'd0, a[8*r +: 8]});
         g = $signed({{16{b[16*r+15]}}, b[16*r +: 16]});
         case (c)
            3'd1: g = $signed({{16{b[15]}}, b[15:0]});
            3'd2: g = $signed({{16{b[31]}}, b[31:16]});
            3'd3, 3'd5: f = $signed({{24{hb[7]}}, hb});
            3'd4, 3'd6: f = $signed({24'd0, lb});
            default: ;
         endcase
         p = f * g;
         if (p[7:0] > 8'h7F) p = p + 32'sd256;
         if (c <= 3'd4) res[16*r +: 16] = p[23:8];
         else if (c <= 3'd6 && r < 2) res[32*r +: 32] = p;
      end
      return res;
   endfunction

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Issue one operation and check it on the following cycle.
   task automatic issue(input string req, input logic [2:0] c,
                        input logic [63:0] a, input logic [63:0] b,
                        input logic [63:0] exp);
      @(negedge clk);
      in_valid = 1'b1; op = c; src_a = a; src_b = b;
      @(negedge clk);
      in_valid = 1'b0;
      check({req, " valid"}, {63'd0, out_valid}, 64'd1);
      check(req, result, exp);
   endtask

   task automatic t_reset();
      @(negedge clk); rst = 1'b1;
      @(negedge clk); @(negedge clk);
      check("R1 out_valid", {63'd0, out_valid}, 64'd0);
      check("R1 result", result, 64'd0);
      rst = 1'b0;
   endtask

   task automatic t_rounding();
      issue("R4 0x80 rounds up", 3'd0, 64'h1, 64'h0080, 64'h0001);
      issue("R4 0x7F no round", 3'd0, 64'h1, 64'h007F, 64'h0000);
      issue("R4 negative", 3'd0, 64'hFF, 64'hFFFF, 64'hFFFF);
      issue("R3 lane positions", 3'd0, 64'h0403_0201, 64'h0100_0100_0100_0100,
            64'h0004_0003_0002_0001);
   endtask

   task automatic t_wide();
      issue("R8 unsigned low byte", 3'd6, 64'hAAAA_BBBB_00FF_1203,
            64'h5555_6666_0081_0100, 64'h0000_807F_0000_0300);
      issue("R8 signed high byte", 3'd5, 64'h1111_2222_8000_FE00,
            64'h3333_4444_0001_0041, 64'h0000_0080_FFFF_FF7E);
   endtask

   task automatic t_ops_random();
      string tags [8] = '{"R3 per-lane", "R5 broadcast 0", "R5 broadcast 1",
                          "R6 signed high", "R7 unsigned low", "R8 wide signed",
                          "R8 wide unsigned", "R9 unused code"};
      for (int c = 0; c < 8; c++) begin
         for (int k = 0; k < 6; k++) begin
            logic [63:0] a, b;
            a = next_rand();
            b = next_rand();
            issue(tags[c], 3'(c), a, b, ref_mul(3'(c), a, b));
         end
      end
      issue("R3 zero factor", 3'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 64'd0);
   endtask

   task automatic t_hold();
      logic [63:0] held;
      issue("R2 load", 3'd0, 64'h0000_0000_1020_3040, 64'h0200_0300_0400_0500,
            ref_mul(3'd0, 64'h0000_0000_1020_3040, 64'h0200_0300_0400_0500));
      held = result;
      @(negedge clk);
      op = 3'd4; src_a = 64'hDEAD_BEEF_CAFE_F00D; src_b = 64'h1234_5678_9ABC_DEF0;
      check("R2 idle out_valid", {63'd0, out_valid}, 64'd0);
      check("R2 idle hold", result, held);
      @(negedge clk);
      check("R2 idle hold 2", result, held);
   endtask

   initial begin
      t_reset();
      t_rounding();
      t_wide();
      t_ops_random();
      t_hold();
      t_reset();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #1000000;
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule